// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two binary32 operands and returns a binary32 result, together with flags that report when the result left the normal range at the top or at the bottom. A one-bit select picks the operation. When it is set, the sign of the second operand is flipped before the addition. An operand is offered by raising `in_valid` for one cycle. The block is fully pipelined, so it accepts a new pair on every cycle, and each result appears with `out_valid` exactly two cycles after its operands.

The first stage does four things:
- It decodes the reserved exponent codes.
- It orders the operands by magnitude.
- It restores the implicit leading one.
- It shifts the smaller significand right by the exponent difference, keeping a guard bit, a round bit and a sticky bit, and then adds or subtracts.

The second stage does four things:
- It normalizes the sum in either direction.
- It rounds to nearest with ties to even.
- It normalizes once more if rounding carries out of the significand.
- It drops the leading one and packs the result.

Subnormal operands are read as zero, and subnormal results are flushed to zero.

Top module: `fp32_addsub`

## Requirements
- R1: For normal operands with an exact result, the block returns the exact encoding. Examples are 1.0+1.0 = 0x40000000, 1.0+2.0 = 0x40400000, and 0x3F200000 + 0xBE000000 = 0x3F000000.
- R2: The smaller operand is shifted right with guard, round and sticky bits. An exponent difference of 26 or more leaves only the sticky bit, set when the shifted significand is nonzero.
- R3: When `sub_sel` is 1, the result is a minus b. Effective subtraction normalizes left when leading bits cancel, for example 1.5-1.0 = 0x3F000000.
- R4: Rounding is to nearest, with ties going to the even significand. Example results:
  - 0x3F800000 + 0x33800000 = 0x3F800000
  - 0x3F800001 + 0x33800000 = 0x3F800002
  - 0x3F800000 + 0x33C00000 = 0x3F800001
- R5: If rounding carries out of the 24-bit significand, the result is renormalized with the exponent raised by one. Example: 0x3FFFFFFF + 0x33800000 = 0x40000000.
- R6: A result exponent of 255 or more gives infinity with the result's sign, and `ovf_flag` is set to 1.
- R7: A result exponent of 0 or less gives a zero with the result's sign, and `unf_flag` is set to 1. An operand whose exponent field is 0 is treated as zero.
- R8: A NaN operand, or infinities of opposite effective sign, gives 0x7FC00000 with both flags at 0.
- R9: An infinite operand gives an infinity with that operand's effective sign, and both flags are 0.
- R10: Exact cancellation of nonzero values gives +0. A sum of two zeros is -0 only when both have effective sign 1.
- R11: While reset is active, and when no input is offered, `out_valid` is 0. Each accepted pair gives exactly one result with `out_valid` = 1, two cycles after acceptance, and one pair can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operands are offered this cycle |
| op_a | input | 32 | First operand, binary32 encoding |
| op_b | input | 32 | Second operand, binary32 encoding |
| sub_sel | input | 1 | 1 selects op_a - op_b; 0 selects op_a + op_b |
| out_valid | output | 1 | The result and the flags are valid this cycle |
| result | output | 32 | Sum or difference, binary32 encoding |
| ovf_flag | output | 1 | Result saturated to infinity |
| unf_flag | output | 1 | Result flushed to zero |

## Verification
Rounding and exponent overflow can occur in the same cycle. This happens when a sum whose exponent is already at the largest finite value rounds upward and carries out of the significand, so the renormalization pushes the exponent to 255. The bench provokes this with 0x7F7FFFFF + 0x73000000, which is an exact tie with an odd significand. It expects 0x7F800000 with the overflow flag set, and it expects no wrapped finite value. Cancellation and flushing can also coincide: 0x00800000 - 0x00C00000 normalizes left below exponent 1, and it must return 0x80000000 with the underflow flag set.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int XTRA    = 2;                 // guard and round positions
  localparam int ALN_W   = SIG_W + XTRA;      // aligned significand without sticky
  localparam int NRM_W   = ALN_W + 1;         // plus sticky
  localparam int SUM_W   = NRM_W + 1;         // plus carry
  localparam int ESUM_W  = EXP_W + 2;         // signed exponent headroom
  localparam int LZ_W    = $clog2(SUM_W);
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic              special;
    logic [WORD_W-1:0] spec_word;
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [SUM_W-1:0]  sum;
  } mid_t;

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [NRM_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            seen;
    n    = '0;
    seen = 1'b0;
    for (int i = NRM_W - 1; i >= 0; i--) begin
      if (!seen) begin
        if (v[i]) seen = 1'b1;
        else      n    = n + 1'b1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
(
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              sub_sel,
  output mid_t              mid
);
  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic              zero_a, zero_b, inf_a, inf_b, nan_a, nan_b;
  logic [WORD_W-2:0] mag_a, mag_b;
  logic              a_big;
  logic              s_big, s_sml;
  logic [EXP_W-1:0]  e_big, e_sml, diff;
  logic [SIG_W-1:0]  sig_big, sig_sml;
  logic [2*ALN_W-1:0] wide_sh;
  logic [ALN_W-1:0]  shifted;
  logic              stk, far, eff_sub;
  logic [SUM_W-1:0]  big_x, sml_x;

  always_comb begin
    sa = op_a[WORD_W-1];
    sb = op_b[WORD_W-1] ^ sub_sel;
    ea = op_a[WORD_W-2 -: EXP_W];
    eb = op_b[WORD_W-2 -: EXP_W];
    fa = op_a[FRAC_W-1:0];
    fb = op_b[FRAC_W-1:0];

    zero_a = (ea == '0);
    zero_b = (eb == '0);
    inf_a  = (ea == EXP_W'(EXP_MAX)) && (fa == '0);
    inf_b  = (eb == EXP_W'(EXP_MAX)) && (fb == '0);
    nan_a  = (ea == EXP_W'(EXP_MAX)) && (fa != '0);
    nan_b  = (eb == EXP_W'(EXP_MAX)) && (fb != '0);

    // flushed magnitudes decide which operand keeps its exponent
    mag_a = zero_a ? '0 : op_a[WORD_W-2:0];
    mag_b = zero_b ? '0 : op_b[WORD_W-2:0];
    a_big = (mag_a >= mag_b);

    s_big   = a_big ? sa : sb;
    s_sml   = a_big ? sb : sa;
    e_big   = a_big ? ea : eb;
    e_sml   = a_big ? eb : ea;
    sig_big = a_big ? (zero_a ? '0 : {1'b1, fa}) : (zero_b ? '0 : {1'b1, fb});
    sig_sml = a_big ? (zero_b ? '0 : {1'b1, fb}) : (zero_a ? '0 : {1'b1, fa});
    diff    = e_big - e_sml;

    // alignment: everything pushed below the round bit folds into sticky
    far     = (diff >= EXP_W'(ALN_W));
    wide_sh = {sig_sml, {XTRA{1'b0}}, {ALN_W{1'b0}}} >> diff;
    shifted = far ? '0 : wide_sh[2*ALN_W-1:ALN_W];
    stk     = far ? (|sig_sml) : (|wide_sh[ALN_W-1:0]);

    eff_sub = s_big ^ s_sml;
    big_x   = {1'b0, sig_big, {XTRA{1'b0}}, 1'b0};
    sml_x   = {1'b0, shifted, stk};

    mid.sign = s_big;
    mid.exp  = e_big;
    mid.sum  = eff_sub ? (big_x - sml_x) : (big_x + sml_x);

    // reserved encodings bypass the datapath
    mid.special   = 1'b1;
    mid.spec_word = QNAN;
    if (nan_a || nan_b || (inf_a && inf_b && (sa ^ sb))) begin
      mid.spec_word = QNAN;
    end else if (inf_a) begin
      mid.spec_word = {sa, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (inf_b) begin
      mid.spec_word = {sb, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (zero_a && zero_b) begin
      mid.spec_word = {sa & sb, {(WORD_W-1){1'b0}}};
    end else begin
      mid.special = 1'b0;
    end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  mid_t              mid,
  output logic [WORD_W-1:0] word,
  output logic              ovf,
  output logic              unf
);
  logic                     carry;
  logic [LZ_W-1:0]          lz;
  logic [NRM_W-1:0]         nrm;
  logic signed [ESUM_W-1:0] e_base, e_n, e_r;
  logic [SIG_W-1:0]         mant, mant_f;
  logic [SIG_W:0]           rnd;
  logic                     g_bit, rs_bits, up;

  always_comb begin
    e_base = $signed({{(ESUM_W-EXP_W){1'b0}}, mid.exp});
    carry  = mid.sum[SUM_W-1];
    lz     = lead_zeros(mid.sum[NRM_W-1:0]);
    if (carry) begin
      nrm = {mid.sum[SUM_W-1:2], |mid.sum[1:0]};
      e_n = e_base + ESUM_W'(1);
    end else begin
      nrm = mid.sum[NRM_W-1:0] << lz;
      e_n = e_base - $signed({{(ESUM_W-LZ_W){1'b0}}, lz});
    end

    mant    = nrm[NRM_W-1 -: SIG_W];
    g_bit   = nrm[XTRA];
    rs_bits = |nrm[XTRA-1:0];
    up      = g_bit & (rs_bits | mant[0]);
    rnd     = {1'b0, mant} + {{SIG_W{1'b0}}, up};
    if (rnd[SIG_W]) begin
      mant_f = rnd[SIG_W:1];
      e_r    = e_n + ESUM_W'(1);
    end else begin
      mant_f = rnd[SIG_W-1:0];
      e_r    = e_n;
    end

    ovf = 1'b0;
    unf = 1'b0;
    if (mid.special) begin
      word = mid.spec_word;
    end else if (mid.sum == '0) begin
      word = '0;
    end else if (e_r >= $signed(ESUM_W'(EXP_MAX))) begin
      word = {mid.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf  = 1'b1;
    end else if (e_r <= $signed(ESUM_W'(0))) begin
      word = {mid.sign, {(WORD_W-1){1'b0}}};
      unf  = 1'b1;
    end else begin
      word = {mid.sign, e_r[EXP_W-1:0], mant_f[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              sub_sel,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              ovf_flag,
  output logic              unf_flag
);
  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  mid_t              mid_d, mid_q;
  logic              v1_q, v1_d, v2_d;
  logic [WORD_W-1:0] word_d;
  logic              ovf_d, unf_d;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  fpadd_align u_align (.op_a(op_a), .op_b(op_b), .sub_sel(sub_sel), .mid(mid_d));
  fpadd_round u_round (.mid(mid_q), .word(word_d), .ovf(ovf_d), .unf(unf_d));

  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      v1_q      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1_q      <= v1_d;
      out_valid <= v2_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) mid_q <= mid_d;
  end

  always_ff @(posedge clk) begin
    if (v1_q) begin
      result   <= word_d;
      ovf_flag <= ovf_d;
      unf_flag <= unf_d;
    end
  end

  // R11: every accepted pair reaches the output two cycles later
  a_r11_stage1: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> v1_q);
  a_r11_stage2: assert property (@(posedge clk) disable iff (!rst_s_n)
    v1_q |=> out_valid);
  // R6: overflow flag always accompanies an infinity encoding
  a_r6_ovf_inf: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && ovf_flag) |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  // R7: underflow flag always accompanies a zero encoding
  a_r7_unf_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && unf_flag) |-> (result[WORD_W-2:0] == '0));
  // R6/R7: flags never raised together
  a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> !(ovf_flag && unf_flag));
  // R8: every NaN that leaves the block is the single quiet pattern
  a_r8_nan_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && (result[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}}) && (result[FRAC_W-1:0] != '0))
      |-> (result == QNAN));
endmodule

// File: tb/fp32_addsub_tb_top.sv
module fp32_addsub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        sub_sel = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf_flag, unf_flag;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;

  typedef struct {
    logic [31:0] word;
    logic        ovf;
    logic        unf;
    int          due;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  fp32_addsub dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub_sel(sub_sel), .out_valid(out_valid), .result(result),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag));

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, expv);
    end
  endtask

  // driver: offer one pair at a falling edge and queue its expectation
  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic s,
                      input logic [31:0] w, input logic o, input logic u, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; sub_sel = s;
    e.word = w; e.ovf = o; e.unf = u; e.due = cycle + 2; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; op_a = '0; op_b = '0; sub_sel = 1'b0;
    end
  endtask

  // monitor: compare each result against the head of the queue
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R11", "unexpected out_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(result == e.word, e.req, "result", result, e.word);
        check({ovf_flag, unf_flag} == {e.ovf, e.unf}, e.req, "flags {ovf,unf}",
              {30'd0, ovf_flag, unf_flag}, {30'd0, e.ovf, e.unf});
        check(cycle == e.due, "R11", "latency cycle", cycle, e.due);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    idle(4);
    check(out_valid == 1'b0, "R11", "out_valid idle", {31'd0, out_valid}, 32'd0);

    // back-to-back burst
    send(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 0, 0, "R1");
    send(32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, 0, 0, "R1");
    send(32'h3F200000, 32'hBE000000, 1'b0, 32'h3F000000, 0, 0, "R1");
    send(32'h3F200000, 32'h3E000000, 1'b1, 32'h3F000000, 0, 0, "R3");
    send(32'h3FC00000, 32'h3F800000, 1'b1, 32'h3F000000, 0, 0, "R3");
    send(32'h40000000, 32'hBF800000, 1'b0, 32'h3F800000, 0, 0, "R3");
    send(32'h3F800000, 32'h0D800000, 1'b0, 32'h3F800000, 0, 0, "R2");
    send(32'h3F800000, 32'h0D800000, 1'b1, 32'h3F800000, 0, 0, "R2");
    send(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 0, 0, "R4");
    send(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 0, 0, "R4");
    send(32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 0, 0, "R4");
    send(32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 0, 0, "R5");
    send(32'h3FFFFFFF, 32'h3FFFFFFF, 1'b0, 32'h407FFFFF, 0, 0, "R5");
    idle(3);
    // overflow, including round carry into the top exponent
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1, 0, "R6");
    send(32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1, 0, "R6");
    send(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 1, 0, "R6");
    // underflow and flushed operands
    send(32'h00800000, 32'h00C00000, 1'b1, 32'h80000000, 0, 1, "R7");
    send(32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 0, 0, "R7");
    // NaN and infinity handling
    send(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 0, 0, "R8");
    send(32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, 0, 0, "R8");
    send(32'h7F800001, 32'h3F800000, 1'b0, 32'h7FC00000, 0, 0, "R8");
    send(32'h3F800000, 32'hFFC12345, 1'b1, 32'h7FC00000, 0, 0, "R8");
    send(32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 0, 0, "R9");
    send(32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 0, 0, "R9");
    send(32'hFF800000, 32'hFF800000, 1'b0, 32'hFF800000, 0, 0, "R9");
    // cancellation and signed zeros
    send(32'h40490FDB, 32'h40490FDB, 1'b1, 32'h00000000, 0, 0, "R10");
    send(32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 0, 0, "R10");
    send(32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 0, 0, "R10");
    send(32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 0, 0, "R10");
    send(32'h00000000, 32'h80000000, 1'b0, 32'h00000000, 0, 0, "R10");
    idle(6);
    check(sb_q.size() == 0, "R11", "results outstanding", sb_q.size(), 32'd0);
    check(out_valid == 1'b0, "R11", "out_valid after drain", {31'd0, out_valid}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule